// File: doc/BRIEF.md
# GPIO Pad Controller with Edge and Level Interrupts

The block gives software a memory-mapped view of a parameterised set of general-purpose pads. Each pad has a 16-byte register window. The window holds a trigger/mux configuration word, a free configuration word, a value word and a read-only debug word. The value word carries two active-low enables, one for the input path and one for the output driver, plus the pad level. When the driver is enabled, the level written to the value word appears on `pad_out`.

Every pad input passes through a two-flop synchroniser. The synchronised level is then compared with its value from the previous cycle. Each pad's trigger bits select one of these interrupt conditions:

- rising edge
- falling edge
- both edges
- active-high level
- active-low level
- none

A detected condition sets a sticky pending bit. Pending bits are packed 32 pads to a word in a separate status region at byte address 0x800. Software clears them by writing ones. A registered interrupt line reports whether any pad is pending.

The bus is a plain 32-bit word interface. A write takes effect on the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr` and the current state.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset, every trigger/mux word and free configuration word reads 0, every value word reads 0x0000_0006 (both enables off, level 0), every status word reads 0, and `irq_out` is 0.
- R2: Pad k's window starts at byte k*16. Offset 0x0 is the trigger/mux word, and only bits 26:24 and 2:0 are kept. Offset 0x4 is a fully writable 32-bit word. Offset 0x8 is the value word. Offset 0xC is read-only and returns the synchronised pad input in bit 0.
- R3: The following accesses read 0 and their writes change nothing: an address whose two low bits are not zero, a pad window at or beyond NUM_PADS, and a status word beyond the last implemented one.
- R4: In the value word, bit 1 is the output enable (0 = driving), bit 2 is the input enable (0 = enabled), and bit 0 is the level. `pad_oe[k]` is the inverse of bit 1 and `pad_out[k]` equals bit 0. A read of bit 0 returns the written level when driving. Otherwise it returns the synchronised input when the input is enabled, and 0 when neither is enabled.
- R5: With bit 24 clear, bit 25 alone selects rising edges, bit 26 alone selects falling edges, and both bits together select either edge.
- R6: With bit 24 set, bit 25 selects active-high level and bit 26 selects active-low level. While the level stays active, the pending bit stays set through a clear.
- R7: A pad with bits 26:24 all zero never becomes pending. A pad with only bit 24 set also never becomes pending.
- R8: Pad k's pending flag is bit k%32 of the word at 0x800 + (k/32)*4. A write clears exactly the bits written as 1, and writing 0xFFFF_FFFF clears the whole word.
- R9: A detected event in the same cycle as a clear of its bit leaves the bit set.
- R10: Suppose a pad input changes before clock edge E. Then the pending bit for that change is first visible after edge E+2.
- R11: `irq_out` is the OR of all pending bits as they stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | NUM_PADS | Asynchronous pad input levels |
| pad_out | output | NUM_PADS | Level driven on each pad |
| pad_oe | output | NUM_PADS | Driver enable per pad, active high |
| irq_out | output | 1 | Any pad pending, registered |

## Verification
The hardest case to reach is a clear that lands in the exact cycle a new edge is detected on the same pad. The three-stage input path hides that cycle from the ports. To reach it, the bench first leaves the bit pending. It then returns the pad to idle, raises it again, waits one negative edge, and issues the write-one-to-clear so that it lines up with the detection cycle. A level pad held active across a clear, and a bit-selective mask that names both set and unset bits, cover the other ways a clear can race a set. A behavioural model predicts every read word, pad output and the interrupt line on each cycle.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam logic [31:0] STAT_BASE = 32'h0000_0800;
  localparam logic [31:0] TRIG_KEEP = 32'h0700_0007;
  localparam logic [2:0]  VAL_RESET = 3'b110;

  typedef enum logic [1:0] {
    SLOT_TRIG = 2'd0,
    SLOT_FREE = 2'd1,
    SLOT_VAL  = 2'd2,
    SLOT_DBG  = 2'd3
  } slot_e;

  // bit order matches config bits 26:24
  typedef struct packed {
    logic fall_sel;
    logic rise_sel;
    logic lvl_mode;
  } trig_t;

  function automatic logic trig_event(trig_t t, logic now_lvl, logic old_lvl);
    if (t.lvl_mode)
      return (t.rise_sel & now_lvl) | (t.fall_sel & ~now_lvl);
    return (t.rise_sel & now_lvl & ~old_lvl) | (t.fall_sel & ~now_lvl & old_lvl);
  endfunction

  // value word: [2] input enable (low), [1] output enable (low), [0] level
  function automatic logic val_readback(logic [2:0] v, logic sync_lvl);
    if (!v[1]) return v[0];
    if (!v[2]) return sync_lvl;
    return 1'b0;
  endfunction

  function automatic logic pad_hit(logic [31:0] a, int unsigned npads);
    return (a[1:0] == 2'b00) && (a < STAT_BASE) && ((a >> 4) < npads);
  endfunction

  function automatic logic stat_hit(logic [31:0] a, int unsigned nwords);
    return (a[1:0] == 2'b00) && (a >= STAT_BASE) && (((a - STAT_BASE) >> 2) < nwords);
  endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int unsigned NUM_PADS = 32,
  parameter int unsigned STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] sync_q,
  output logic [NUM_PADS-1:0] prev_q
);

  logic [NUM_PADS-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= pad_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_q = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_q;
  end

endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
  import gpio_pad_pkg::*;
#(
  parameter int unsigned NUM_PADS = 32,
  parameter int unsigned PAD_W    = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_pad,
  input  logic [PAD_W-1:0]               pad_sel,
  input  slot_e                          slot,
  input  logic [WORD_W-1:0]              wdata,
  output logic [NUM_PADS-1:0][WORD_W-1:0] trig_word,
  output logic [NUM_PADS-1:0][WORD_W-1:0] free_word,
  output logic [NUM_PADS-1:0][2:0]        val_word
);

  generate
    for (genvar k = 0; k < NUM_PADS; k++) begin : g_pad
      logic sel_k;
      assign sel_k = wr_pad && (pad_sel == PAD_W'(k));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          trig_word[k] <= '0;
          free_word[k] <= '0;
          val_word[k]  <= VAL_RESET;
        end else if (sel_k) begin
          case (slot)
            SLOT_TRIG: trig_word[k] <= wdata & TRIG_KEEP;
            SLOT_FREE: free_word[k] <= wdata;
            SLOT_VAL:  val_word[k]  <= wdata[2:0];
            default:   ;
          endcase
        end
      end
    end
  endgenerate

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
  import gpio_pad_pkg::*;
#(
  parameter int unsigned NUM_PADS = 32,
  parameter int unsigned WSEL_W   = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pad_evt,
  input  logic                clr_wr,
  input  logic [WSEL_W-1:0]   word_sel,
  input  logic [WORD_W-1:0]   wdata,
  output logic [NUM_PADS-1:0] clr_vec,
  output logic [NUM_PADS-1:0] status_q,
  output logic                irq_q
);

  generate
    for (genvar k = 0; k < NUM_PADS; k++) begin : g_clr
      localparam int unsigned WIDX = k / 32;
      localparam int unsigned BIDX = k % 32;
      assign clr_vec[k] = clr_wr && (word_sel == WSEL_W'(WIDX)) && wdata[BIDX];
    end
  endgenerate

  // a new event outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_vec) | pad_evt;
      irq_q    <= |status_q;
    end
  end

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pad_pkg::*;
#(
  parameter int unsigned NUM_PADS    = 32,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic                irq_out
);

  localparam int unsigned NUM_WORDS = (NUM_PADS + 31) / 32;
  localparam int unsigned PAD_W     = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;
  localparam int unsigned WSEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic [31:0]         addr_ext;
  logic                hit_pad, hit_stat;
  logic [PAD_W-1:0]    pad_idx;
  logic [WSEL_W-1:0]   word_idx;
  slot_e               slot;

  logic [NUM_PADS-1:0] sync_q, prev_q;
  logic [NUM_PADS-1:0] pad_evt, stat_clr, status_q;
  logic [NUM_PADS-1:0][WORD_W-1:0] trig_word, free_word;
  logic [NUM_PADS-1:0][2:0]        val_word;

  assign addr_ext = 32'(bus_addr);
  assign hit_pad  = pad_hit(addr_ext, NUM_PADS);
  assign hit_stat = stat_hit(addr_ext, NUM_WORDS);
  assign pad_idx  = addr_ext[4 +: PAD_W];
  assign word_idx = addr_ext[2 +: WSEL_W];
  assign slot     = slot_e'(addr_ext[3:2]);

  gpio_pad_sync #(
    .NUM_PADS (NUM_PADS),
    .STAGES   (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad_in (pad_in),
    .sync_q (sync_q),
    .prev_q (prev_q)
  );

  gpio_pad_bank #(
    .NUM_PADS (NUM_PADS),
    .PAD_W    (PAD_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_pad    (bus_wr && hit_pad),
    .pad_sel   (pad_idx),
    .slot      (slot),
    .wdata     (bus_wdata),
    .trig_word (trig_word),
    .free_word (free_word),
    .val_word  (val_word)
  );

  generate
    for (genvar k = 0; k < NUM_PADS; k++) begin : g_pad
      assign pad_evt[k] = trig_event(trig_t'(trig_word[k][26:24]), sync_q[k], prev_q[k]);
      assign pad_out[k] = val_word[k][0];
      assign pad_oe[k]  = ~val_word[k][1];
    end
  endgenerate

  gpio_irq_status #(
    .NUM_PADS (NUM_PADS),
    .WSEL_W   (WSEL_W)
  ) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_evt  (pad_evt),
    .clr_wr   (bus_wr && hit_stat),
    .word_sel (word_idx),
    .wdata    (bus_wdata),
    .clr_vec  (stat_clr),
    .status_q (status_q),
    .irq_q    (irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit_pad) begin
      case (slot)
        SLOT_TRIG: bus_rdata = trig_word[pad_idx];
        SLOT_FREE: bus_rdata = free_word[pad_idx];
        SLOT_VAL:  bus_rdata = {29'd0, val_word[pad_idx][2:1],
                                val_readback(val_word[pad_idx], sync_q[pad_idx])};
        default:   bus_rdata = {31'd0, sync_q[pad_idx]};
      endcase
    end else if (hit_stat) begin
      for (int k = 0; k < int'(NUM_PADS); k++) begin
        if (WSEL_W'(k / 32) == word_idx) bus_rdata[k % 32] = status_q[k];
      end
    end
  end

endmodule

// File: rtl/gpio_pad_ctrl_checker.sv
module gpio_pad_ctrl_checker #(
  parameter int unsigned NUM_PADS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PADS-1:0] pad_evt,
  input logic [NUM_PADS-1:0] stat_clr,
  input logic [NUM_PADS-1:0] status,
  input logic                irq_out
);

  // R9: a detected event is pending on the next cycle, clear or not
  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pad_evt) & ~status) == '0));

  // R8: a pending bit only appears after a detected event
  assert_set_needs_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status) & ~$past(pad_evt)) == '0));

  // R8: a pending bit only drops after a write of one to it
  assert_drop_needs_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((~status & $past(status) & ~$past(stat_clr)) == '0));

  // R11: interrupt follows the OR of the previous cycle's pending bits
  assert_irq_or_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out == (|$past(status))));

endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_checker #(.NUM_PADS(NUM_PADS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pad_evt  (pad_evt),
  .stat_clr (stat_clr),
  .status   (status_q),
  .irq_out  (irq_out)
);

// File: tb/gpio_pad_ctrl_bench.sv
module gpio_pad_ctrl_bench;

  localparam int NP = 32;
  localparam int NW = (NP + 31) / 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic          irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_pad_ctrl #(.NUM_PADS(NP), .ADDR_W(12), .SYNC_STAGES(2)) u_gpio_pad_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
  );

  // ---------------- behavioural reference ----------------
  bit [NP-1:0] m_s1, m_s2, m_prev, m_st;
  bit          m_irq;
  logic [31:0] m_trig [NP];
  logic [31:0] m_free [NP];
  logic [2:0]  m_val  [NP];

  function automatic logic [31:0] m_read(logic [11:0] a);
    int p, w;
    logic [31:0] r;
    r = '0;
    if (a[1:0] != 0) return r;
    if (a < 12'h800) begin
      p = int'(a) / 16;
      if (p >= NP) return r;
      case (int'(a) % 16)
        0:  r = m_trig[p];
        4:  r = m_free[p];
        8: begin
          r[2:1] = m_val[p][2:1];
          if (m_val[p][1] == 1'b0)      r[0] = m_val[p][0];
          else if (m_val[p][2] == 1'b0) r[0] = m_s2[p];
        end
        default: r[0] = m_s2[p];
      endcase
    end else begin
      w = (int'(a) - 'h800) / 4;
      if (w >= NW) return r;
      for (int b = 0; b < 32; b++)
        if (w * 32 + b < NP) r[b] = m_st[w * 32 + b];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_st = '0; m_irq = 0;
      for (int k = 0; k < NP; k++) begin
        m_trig[k] = '0; m_free[k] = '0; m_val[k] = 3'b110;
      end
    end else begin
      bit [NP-1:0] ev, clr;
      ev = '0; clr = '0;
      for (int k = 0; k < NP; k++) begin
        bit lv, rs, fl;
        lv = m_trig[k][24]; rs = m_trig[k][25]; fl = m_trig[k][26];
        if (lv) ev[k] = (rs && m_s2[k]) || (fl && !m_s2[k]);
        else    ev[k] = (rs && m_s2[k] && !m_prev[k]) || (fl && !m_s2[k] && m_prev[k]);
      end
      if (bus_wr && bus_addr[1:0] == 0) begin
        if (bus_addr < 12'h800) begin
          int p;
          p = int'(bus_addr) / 16;
          if (p < NP) begin
            case (int'(bus_addr) % 16)
              0: m_trig[p] = bus_wdata & 32'h0700_0007;
              4: m_free[p] = bus_wdata;
              8: m_val[p]  = bus_wdata[2:0];
              default: ;
            endcase
          end
        end else begin
          int w;
          w = (int'(bus_addr) - 'h800) / 4;
          if (w < NW)
            for (int b = 0; b < 32; b++)
              if (w * 32 + b < NP) clr[w * 32 + b] = bus_wdata[b];
        end
      end
      m_irq  = (m_st != 0);
      m_st   = (m_st & ~clr) | ev;
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = pad_in;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic [NP-1:0] eo, ep;
      for (int k = 0; k < NP; k++) begin
        eo[k] = m_val[k][0];
        ep[k] = ~m_val[k][1];
      end
      chk(bus_rdata === m_read(bus_addr), "R2 read word vs model", bus_rdata, m_read(bus_addr));
      chk(irq_out === m_irq, "R11 irq vs model", 32'(irq_out), 32'(m_irq));
      chk(pad_out === eo, "R4 pad_out vs model", 32'(pad_out), 32'(eo));
      chk(pad_oe === ep, "R4 pad_oe vs model", 32'(pad_oe), 32'(ep));
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #2;
    chk(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  task automatic setpad(input int k, input bit v);
    @(negedge clk);
    pad_in[k] = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog expired (all requirements)");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(12'h000, 32'h0, "R1 trig word after reset");
    rd(12'h014, 32'h0, "R1 free word after reset");
    rd(12'h008, 32'h6, "R1 value word after reset");
    rd(12'h800, 32'h0, "R1 status after reset");
    chk(irq_out === 1'b0, "R1 irq after reset", 32'(irq_out), 0);

    // R2 window layout
    wr(12'h030, 32'hFAFF_FFFD);
    rd(12'h030, 32'h0200_0005, "R2 trig word keeps 26:24 and 2:0");
    wr(12'h030, 32'h0);
    wr(12'h034, 32'hA5A5_1234);
    rd(12'h034, 32'hA5A5_1234, "R2 free word readback");
    setpad(3, 1'b1);
    idle(3);
    rd(12'h03C, 32'h1, "R2 debug word shows synchronised input");
    wr(12'h03C, 32'hFFFF_FFFF);
    rd(12'h03C, 32'h1, "R2 debug word is read-only");

    // R3 unmapped space
    wr(12'h200, 32'hFFFF_FFFF);
    rd(12'h200, 32'h0, "R3 pad window beyond NUM_PADS");
    wr(12'h804, 32'hFFFF_FFFF);
    rd(12'h804, 32'h0, "R3 status word beyond last");
    wr(12'h001, 32'hFFFF_FFFF);
    rd(12'h000, 32'h0, "R3 unaligned write ignored");
    rd(12'h001, 32'h0, "R3 unaligned read zero");

    // R4 value word
    wr(12'h058, 32'h5);
    rd(12'h058, 32'h5, "R4 driving level reads back");
    chk(pad_oe[5] === 1'b1 && pad_out[5] === 1'b1, "R4 pad driven high",
        {30'd0, pad_oe[5], pad_out[5]}, 32'h3);
    wr(12'h058, 32'h3);
    rd(12'h058, 32'h2, "R4 input enabled, pad low");
    setpad(5, 1'b1);
    idle(3);
    rd(12'h058, 32'h3, "R4 input enabled, pad high");
    chk(pad_oe[5] === 1'b0, "R4 driver off", 32'(pad_oe[5]), 0);

    // R5 edge modes
    wr(12'h800, 32'hFFFF_FFFF);
    wr(12'h010, 32'h0200_0000);
    wr(12'h020, 32'h0400_0000);
    wr(12'h040, 32'h0600_0000);
    setpad(1, 1'b1); idle(4);
    rd(12'h800, 32'h0000_0002, "R5 rising edge pending");
    wr(12'h800, 32'h2);
    rd(12'h800, 32'h0, "R5 rising cleared");
    setpad(1, 1'b0); idle(4);
    rd(12'h800, 32'h0, "R5 rising mode ignores fall");
    setpad(2, 1'b1); idle(4);
    rd(12'h800, 32'h0, "R5 falling mode ignores rise");
    setpad(2, 1'b0); idle(4);
    rd(12'h800, 32'h0000_0004, "R5 falling edge pending");
    wr(12'h800, 32'h4);
    setpad(4, 1'b1); idle(4);
    rd(12'h800, 32'h0000_0010, "R5 both-edge rise");
    wr(12'h800, 32'h10);
    setpad(4, 1'b0); idle(4);
    rd(12'h800, 32'h0000_0010, "R5 both-edge fall");
    wr(12'h800, 32'h10);

    // R6 level modes
    wr(12'h060, 32'h0300_0000);
    idle(3);
    rd(12'h800, 32'h0, "R6 level-high idle when low");
    setpad(6, 1'b1); idle(4);
    rd(12'h800, 32'h0000_0040, "R6 level-high pending");
    wr(12'h800, 32'h40);
    rd(12'h800, 32'h0000_0040, "R6 active level survives clear");
    setpad(6, 1'b0); idle(4);
    wr(12'h800, 32'h40);
    rd(12'h800, 32'h0, "R6 clear sticks once inactive");
    wr(12'h070, 32'h0500_0000);
    idle(2);
    rd(12'h800, 32'h0000_0080, "R6 level-low pending");
    setpad(7, 1'b1); idle(4);
    wr(12'h800, 32'h80);
    rd(12'h800, 32'h0, "R6 level-low cleared when high");

    // R7 disabled trigger
    wr(12'h090, 32'h0100_0000);
    for (int i = 0; i < 3; i++) begin
      setpad(8, 1'b1); setpad(9, 1'b1); idle(3);
      setpad(8, 1'b0); setpad(9, 1'b0); idle(3);
    end
    rd(12'h800, 32'h0, "R7 no trigger bits / level alone never pending");

    // R8 selective clear
    setpad(1, 1'b1); setpad(4, 1'b1); idle(4);
    rd(12'h800, 32'h0000_0012, "R8 two pads pending");
    wr(12'h800, 32'h0000_0006);
    rd(12'h800, 32'h0000_0010, "R8 mask clears only its set bits");
    wr(12'h800, 32'hFFFF_FFFF);
    rd(12'h800, 32'h0, "R8 all-ones clears word");

    // R9 edge coinciding with clear
    setpad(1, 1'b0); idle(4);
    setpad(1, 1'b1); idle(4);
    setpad(1, 1'b0); idle(4);
    rd(12'h800, 32'h0000_0002, "R9 bit pending before race");
    setpad(1, 1'b1);
    @(negedge clk);
    wr(12'h800, 32'h2);
    rd(12'h800, 32'h0000_0002, "R9 edge in clear cycle kept");
    wr(12'h800, 32'hFFFF_FFFF);

    // R10 latency, R11 interrupt
    wr(12'h0A0, 32'h0200_0000);
    idle(2);
    @(negedge clk);
    bus_addr = 12'h800;
    pad_in[10] = 1'b1;
    @(negedge clk); #2;
    chk(bus_rdata === 32'h0, "R10 not pending after 1 edge", bus_rdata, 0);
    @(negedge clk); #2;
    chk(bus_rdata === 32'h0, "R10 not pending after 2 edges", bus_rdata, 0);
    @(negedge clk); #2;
    chk(bus_rdata === 32'h0000_0400, "R10 pending after 3 edges", bus_rdata, 32'h400);
    chk(irq_out === 1'b0, "R11 irq one cycle behind", 32'(irq_out), 0);
    @(negedge clk); #2;
    chk(irq_out === 1'b1, "R11 irq raised", 32'(irq_out), 1);
    wr(12'h800, 32'h400);
    #2;
    chk(irq_out === 1'b1, "R11 irq holds one cycle after clear", 32'(irq_out), 1);
    @(negedge clk); #2;
    chk(irq_out === 1'b0, "R11 irq drops", 32'(irq_out), 0);

    idle(4);
    summary();
  end

endmodule